// File: doc/BRIEF.md
# Successive Approximation ADC Sequencer

This block is the digital half of an 8-bit, 8-channel successive-approximation converter. A single start pulse latches a channel number and a clock setting. The block then runs one conversion. It drives the analog multiplexer code and a sample-enable level, then walks an 8-bit trial code through a binary search. At the end of each bit step it reads one comparator bit. The external DAC and comparator compare the held input against the trial code.

The conversion runs on a slow conversion tick taken from the system clock through a two-level prescaler. One level is a fast/normal select bit and the other is a 2-bit CPU clock code. A conversion always lasts 160 ticks: 12 ticks of sampling, then 8 equal bit steps of 18 ticks each, then 4 ticks of settling. When it completes, the result register is loaded and the done flag rises.

The result is a plain held register with no handshake and no back-pressure. It stays valid until the next completed conversion overwrites it. A consumer reads it whenever done is high.

Top module: `sar_adc_seq`

## Requirements
- R1: The result equals the largest code C for which the comparator reported input >= C. The comparator encoding is `comp_in` = 1 when the input is at or above `trial_code`. Bits are decided MSB first: a trial bit is kept when `comp_in` is 1 and cleared when it is 0. An input of 0 gives 00h, 1 gives 01h, 254 gives FEh and 255 gives FFh.
- R2: `chan_sel` is latched on the cycle a start is accepted. `mux_code` holds that value for the whole conversion and after it.
- R3: `sample_en` is high for exactly 12 conversion ticks, beginning at the accepting edge. `trial_code` is 00h while sampling. It becomes 80h on the edge that ends sampling.
- R4: `done` rises exactly 160 conversion ticks after the accepting edge, which is 160 × divisor system-clock cycles.
- R5: The divisor is latched at start. With `fast_clk_sel` = 0, `cpu_clk_code` values 00, 01 and 11 give divisors of 2, 4 and 16. With `fast_clk_sel` = 1, the same codes give 1, 2 and 8. Code 10 behaves as 11.
- R6: Each bit step lasts 18 ticks and ends with the decision for that bit. The first decision comes 30 ticks after start, and the last comes 156 ticks after start, which is 4 settle ticks before `done`.
- R7: A start request that arrives while a conversion is running is ignored. The channel, the timing and the result are unaffected.
- R8: `done` is cleared on the edge that accepts a start. It is set when the conversion completes and stays set until the next accepted start.
- R9: `result` keeps its previous value until a new conversion completes.
- R10: After reset, `done`, `sample_en`, `result`, `trial_code` and `mux_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, accepted only when idle |
| chan_sel | input | 3 | Channel to convert |
| fast_clk_sel | input | 1 | Prescaler select: 1 selects the faster divisor set |
| cpu_clk_code | input | 2 | CPU clock code choosing the divisor |
| comp_in | input | 1 | Comparator: 1 when input >= trial_code |
| mux_code | output | 3 | Analog multiplexer select |
| sample_en | output | 1 | Sample-and-hold enable |
| trial_code | output | 8 | Code driven to the DAC |
| result | output | 8 | Last completed conversion result |
| done | output | 1 | Conversion-complete flag |

## Verification
Every input code from 0 to 255 is converted at divisor 1 on rotating channels. This shows that the MSB-first keep/clear search lands on the exact code, including both transition corners, and that the right channel is routed. Each of the eight clock-select combinations is then run with an even input. Measuring the sample length, the first and last trial-code changes and the done latency separates a wrong divisor from a wrong split of the conversion into sample, step and settle phases. A start injected mid-conversion with a different channel, followed by a read of the old result, separates ignoring the request from restarting on it or overwriting early.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_STEP   = 2'd2,
    PH_SETTLE = 2'd3
  } phase_t;

  localparam int unsigned DIV_W = 5;

  // Conversion-clock divisor for a select bit and CPU clock code.
  // Code 2'b10 is treated the same as 2'b11.
  function automatic logic [DIV_W-1:0] conv_divisor(input logic fast,
                                                    input logic [1:0] code);
    logic [DIV_W-1:0] d;
    case (code)
      2'b00:   d = fast ? 5'd1 : 5'd2;
      2'b01:   d = fast ? 5'd2 : 5'd4;
      default: d = fast ? 5'd8 : 5'd16;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler
  import sar_adc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(1);
      cnt   <= '0;
    end else if (restart) begin
      div_q <= div_in;
      cnt   <= '0;
    end else if (run) begin
      if (tick) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end

  // With a divisor above one, two ticks are never back to back.
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && div_q > DIV_W'(1) && !restart) |=> !tick); // R5

endmodule

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
  import sar_adc_pkg::*;
#(
  parameter int unsigned RES_BITS     = 8,
  parameter int unsigned SAMPLE_TICKS = 12,
  parameter int unsigned TOTAL_TICKS  = 160,
  localparam int unsigned IDX_W       = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  output logic             busy,
  output logic             sampling,
  output logic             accept,
  output logic             set_en,
  output logic [IDX_W-1:0] set_idx,
  output logic             dec_en,
  output logic [IDX_W-1:0] dec_idx,
  output logic             finish
);

  localparam int unsigned SPARE        = TOTAL_TICKS - SAMPLE_TICKS - RES_BITS;
  localparam int unsigned STEP_TICKS   = SPARE / RES_BITS + 1;
  localparam int unsigned SETTLE_TICKS = TOTAL_TICKS - SAMPLE_TICKS - STEP_TICKS * RES_BITS;
  localparam int unsigned CNT_MAX      = (SAMPLE_TICKS > STEP_TICKS) ? SAMPLE_TICKS : STEP_TICKS;
  localparam int unsigned CNT_W        = $clog2(CNT_MAX + 1);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bit_idx;
  logic             end_sample, end_step, end_settle, last_bit;

  assign busy       = (phase != PH_IDLE);
  assign sampling   = (phase == PH_SAMPLE);
  assign accept     = start && (phase == PH_IDLE);
  assign last_bit   = (bit_idx == '0);
  assign end_sample = (phase == PH_SAMPLE) && tick && (cnt == CNT_W'(SAMPLE_TICKS - 1));
  assign end_step   = (phase == PH_STEP)   && tick && (cnt == CNT_W'(STEP_TICKS - 1));

  generate
    if (SETTLE_TICKS == 0) begin : g_no_settle
      assign end_settle = 1'b0;
      assign finish     = end_step && last_bit;
    end else begin : g_settle
      assign end_settle = (phase == PH_SETTLE) && tick && (cnt == CNT_W'(SETTLE_TICKS - 1));
      assign finish     = end_settle;
    end
  endgenerate

  assign set_en  = end_sample || (end_step && !last_bit);
  assign set_idx = end_sample ? IDX_W'(RES_BITS - 1) : (bit_idx - 1'b1);
  assign dec_en  = end_step;
  assign dec_idx = bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase <= PH_SAMPLE;
            cnt   <= '0;
          end
        end
        PH_SAMPLE: begin
          if (end_sample) begin
            phase   <= PH_STEP;
            cnt     <= '0;
            bit_idx <= IDX_W'(RES_BITS - 1);
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_STEP: begin
          if (end_step) begin
            cnt <= '0;
            if (last_bit) phase <= (SETTLE_TICKS == 0) ? PH_IDLE : PH_SETTLE;
            else          bit_idx <= bit_idx - 1'b1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (end_settle) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // Once sampling has ended, it does not come back until a fresh start.
  AST_NO_RESAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STEP) |=> !sampling); // R3

  // A decision always lands inside an active conversion.
  AST_DECIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |-> busy && !sampling); // R6

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int unsigned RES_BITS = 8,
  localparam int unsigned IDX_W   = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                set_en,
  input  logic [IDX_W-1:0]    set_idx,
  input  logic                dec_en,
  input  logic [IDX_W-1:0]    dec_idx,
  input  logic                comp_in,
  input  logic                finish,
  output logic [RES_BITS-1:0] trial,
  output logic [RES_BITS-1:0] result
);

  logic [RES_BITS-1:0] trial_nxt;
  logic [RES_BITS-1:0] low_mask;

  always_comb begin
    trial_nxt = trial;
    if (dec_en) trial_nxt[dec_idx] = comp_in;
    if (set_en) trial_nxt[set_idx] = 1'b1;
    if (clear)  trial_nxt = '0;
  end

  // Bits at or below the index about to be set.
  always_comb begin
    for (int i = 0; i < RES_BITS; i++) low_mask[i] = (i <= int'(set_idx));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial  <= '0;
      result <= '0;
    end else begin
      trial <= trial_nxt;
      if (finish) result <= trial_nxt;
    end
  end

  // The search only ever sets a bit that lies below every decided bit.
  AST_SEARCH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> ((trial & low_mask) == '0)); // R1

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int unsigned RES_BITS     = 8,
  parameter int unsigned NUM_CH       = 8,
  parameter int unsigned SAMPLE_TICKS = 12,
  parameter int unsigned TOTAL_TICKS  = 160,
  localparam int unsigned CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned IDX_W       = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CH_W-1:0]     chan_sel,
  input  logic                fast_clk_sel,
  input  logic [1:0]          cpu_clk_code,
  input  logic                comp_in,
  output logic [CH_W-1:0]     mux_code,
  output logic                sample_en,
  output logic [RES_BITS-1:0] trial_code,
  output logic [RES_BITS-1:0] result,
  output logic                done
);

  logic             busy, sampling, accept, tick, finish;
  logic             set_en, dec_en;
  logic [IDX_W-1:0] set_idx, dec_idx;

  sar_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .run     (busy),
    .div_in  (conv_divisor(fast_clk_sel, cpu_clk_code)),
    .tick    (tick)
  );

  sar_phase_ctrl #(
    .RES_BITS     (RES_BITS),
    .SAMPLE_TICKS (SAMPLE_TICKS),
    .TOTAL_TICKS  (TOTAL_TICKS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tick     (tick),
    .busy     (busy),
    .sampling (sampling),
    .accept   (accept),
    .set_en   (set_en),
    .set_idx  (set_idx),
    .dec_en   (dec_en),
    .dec_idx  (dec_idx),
    .finish   (finish)
  );

  sar_trial_reg #(.RES_BITS(RES_BITS)) u_trial (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .set_en  (set_en),
    .set_idx (set_idx),
    .dec_en  (dec_en),
    .dec_idx (dec_idx),
    .comp_in (comp_in),
    .finish  (finish),
    .trial   (trial_code),
    .result  (result)
  );

  assign sample_en = sampling;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_code <= '0;
      done     <= 1'b0;
    end else begin
      if (accept) begin
        mux_code <= chan_sel;
        done     <= 1'b0;
      end else if (finish) begin
        done <= 1'b1;
      end
    end
  end

  AST_MUX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mux_code)); // R7

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !done && sample_en); // R8

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done && !sample_en); // R4

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(result)); // R9

  AST_SAMPLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> (trial_code == '0)); // R3

endmodule

// File: tb/sar_adc_seq_test.sv
`timescale 1ns/1ps
module sar_adc_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] chan_sel = '0;
  logic       fast_clk_sel = 1'b0;
  logic [1:0] cpu_clk_code = '0;
  logic       comp_in;
  logic [2:0] mux_code;
  logic       sample_en;
  logic [7:0] trial_code;
  logic [7:0] result;
  logic       done;

  logic [7:0] vin [8];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign comp_in = (vin[mux_code] >= trial_code);

  sar_adc_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
    .fast_clk_sel(fast_clk_sel), .cpu_clk_code(cpu_clk_code),
    .comp_in(comp_in), .mux_code(mux_code), .sample_en(sample_en),
    .trial_code(trial_code), .result(result), .done(done)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_div(input logic fs, input logic [1:0] cc);
    int base;
    case (cc)
      2'b00:   base = 2;
      2'b01:   base = 4;
      default: base = 16;
    endcase
    return fs ? base / 2 : base;
  endfunction

  // One conversion. inj >= 0 injects a start on channel alt at that count
  // and checks the held result against old_res there.
  task automatic run_conv(input int ch, input logic fs, input logic [1:0] cc,
                          input bit timing, input int inj, input int alt,
                          input logic [7:0] old_res);
    int d = exp_div(fs, cc);
    int n = 0;
    int t_samp = -1, t_ch1 = -1, t_ch2 = -1, t_last = -1;
    logic [7:0] prev, first_code;
    bit mux_ok = 1;
    chan_sel = 3'(ch); fast_clk_sel = fs; cpu_clk_code = cc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chan_sel = 3'(ch ^ 3);
    check("R8 done cleared by start", done, 0);
    prev = trial_code;
    first_code = 8'h00;
    while (!done && n < 200 * d) begin
      if (t_samp < 0 && !sample_en) begin
        t_samp = n;
        first_code = trial_code;
      end
      if (trial_code != prev) begin
        if (t_ch1 < 0) t_ch1 = n;
        else if (t_ch2 < 0) t_ch2 = n;
        t_last = n;
        prev = trial_code;
      end
      if (mux_code != 3'(ch)) mux_ok = 0;
      if (n == inj) begin
        check("R9 result held mid-conversion", result, old_res);
        start = 1'b1;
        chan_sel = 3'(alt);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check("R4 done latency", n, 160 * d);
    check("R1 result code", result, vin[ch]);
    check("R2 mux code held", mux_ok, 1);
    if (timing) begin
      check("R3 sample length", t_samp, 12 * d);
      check("R3 first trial code", first_code, 8'h80);
      check("R6 first decision time", t_ch2, 30 * d);
      check("R6 last decision time", t_last, 156 * d);
      check("R5 divisor via sample length", t_samp / 12, d);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) vin[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R10 reset done", done, 0);
    check("R10 reset sample_en", sample_en, 0);
    check("R10 reset result", result, 0);
    check("R10 reset trial_code", trial_code, 0);
    check("R10 reset mux_code", mux_code, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Full code sweep at divisor 1, rotating channels.
    for (int v = 0; v < 256; v++) begin
      vin[v % 8] = 8'(v);
      run_conv(v % 8, 1'b1, 2'b00, 1'b0, -1, 0, 8'h00);
    end
    check("R1 full-scale result stays", result, 8'hFF);

    // Every clock selection, with an even input for the last-decision timing.
    for (int cfg = 0; cfg < 8; cfg++) begin
      vin[cfg] = 8'(8'h5A + cfg * 16);
      run_conv(cfg, cfg[2], 2'(cfg), 1'b1, -1, 0, 8'h00);
    end
    check("R8 done stays set", done, 1);

    // A start during a conversion is ignored.
    vin[2] = 8'h3C;
    vin[5] = 8'hC3;
    run_conv(5, 1'b0, 2'b00, 1'b0, -1, 0, 8'h00);
    run_conv(2, 1'b0, 2'b00, 1'b1, 50, 5, 8'hC3);
    check("R7 injected start ignored", result, 8'h3C);
    repeat (10) @(negedge clk);
    check("R7 no restart after ignored start", sample_en, 0);
    check("R9 result held while idle", result, 8'h3C);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule